// File: doc/BRIEF.md
# Wake Event Holding Sequencer

This block is a companion controller placed between external event sources, such as a motion sensor and a wireless module, and a host processor that is power-cycled often. Events that arrive while the host is powering up, resuming, suspending or powering down are held in a pending latch and are never turned into a wake request at those times. The host learns about held events through a one-byte message exchange. Incoming bytes arrive on a valid strobe. Outgoing bytes leave on a valid/ready pair that stands in for a serial link.

After a suspend message, the block watches a level driven from the host's GPIO power domain. The falling edge of that level marks the start of hardware power-off. The block then waits a settling time equal to the full power-down duration before it acts. If an event is pending at that point, or arrives later while the host is off, a fixed-width wake pulse is issued and the exchange starts over. A heartbeat supervisor samples at a fixed period and raises a fault flag when no byte has come from the host since the previous sample.

Top module: `wake_hold_seq`

## Requirements
- R1: After reset `wake_pulse`, `tx_valid` and `peer_fault` are 0, and the block waits for a host byte.
- R2: A rising edge on source i with `evt_en[i]`=1 sets the pending latch. Before the first query this produces neither a byte nor a wake pulse. A source with `evt_en[i]`=0 has no effect.
- R3: A received query byte 0x51 yields one reply: 0x01 when an event is pending and 0x00 otherwise. The latch clears when a 0x01 byte is accepted (tx_valid and tx_ready). A new event in that same cycle keeps the latch set.
- R4: After a query has been answered and before a suspend, each newly latched event is sent at once as an unprompted 0x01 byte.
- R5: After a suspend byte 0x53, the block sends nothing. Queries are ignored and events are only latched.
- R6: In the suspended state, a falling edge on `host_gpio` starts the settle delay. `wake_pulse` stays low for SETTLE_CYC cycles after the cycle in which the edge is sampled.
- R7: When the delay ends with an event pending, `wake_pulse` is high for exactly WAKE_CYC cycles. The block then waits for a query, and the latch is kept until it is reported.
- R8: When the delay ends with nothing pending, the block stays off. The next enabled event raises `wake_pulse` on the second clock edge after the input rises, for WAKE_CYC cycles.
- R9: Every HB_CYC cycles the heartbeat sample sets `peer_fault` when no byte was received since the last sample, and clears it otherwise. Any byte counts.
- R10: While `tx_valid` is high and `tx_ready` low, `tx_valid` stays high and `tx_data` is unchanged.
- R11: Received bytes other than 0x51 and 0x53 cause no reply and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NSRC | Event source levels, one bit per source |
| evt_en | input | NSRC | Per-source enable mask |
| host_gpio | input | 1 | Level from the host GPIO power domain |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte valid |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter accepts the reply byte |
| wake_pulse | output | 1 | Wake request to the host |
| peer_fault | output | 1 | Host silent over the last heartbeat period |

## Verification
The bench targets the places where a held event could leak out or be lost. These are an event before the first query, which a wrong design would wake or report on, and an event after suspend, which a wrong design would answer or drop. It measures the settle delay and the pulse width to the cycle. An off-by-one in either counter therefore shows up as a shifted edge. It also covers the off state with nothing pending, where a wrong design would either never wake or wake without an event. Back-pressure on the reply port, masked sources and unknown bytes are checked so that a design that changes a held byte, reacts to a disabled source or reacts to noise is caught. The heartbeat flag is checked to rise under silence and to fall after one byte.

// File: rtl/whs_pkg.sv
package whs_pkg;
  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_REPLY  = 3'd1,
    ST_LIVE   = 3'd2,
    ST_SUSP   = 3'd3,
    ST_SETTLE = 3'd4,
    ST_WAKE   = 3'd5,
    ST_OFF    = 3'd6
  } whs_state_e;

  localparam logic [7:0] MSG_QUERY   = 8'h51;
  localparam logic [7:0] MSG_SUSPEND = 8'h53;
  localparam logic [7:0] MSG_YES     = 8'h01;
  localparam logic [7:0] MSG_NO      = 8'h00;
endpackage

// File: rtl/whs_evt_latch.sv
module whs_evt_latch #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_in,
  input  logic [NSRC-1:0] evt_en,
  input  logic            clr,
  output logic            pending
);
  logic [NSRC-1:0] evt_q;
  logic [NSRC-1:0] rise_vec;
  logic            rise_any;
  logic            pending_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q[i] <= 1'b0;
      else        evt_q[i] <= evt_in[i];
    end
    assign rise_vec[i] = evt_in[i] & ~evt_q[i] & evt_en[i];
  end

  assign rise_any = |rise_vec;

  // A new event wins over a clear in the same cycle
  always_comb begin
    pending_d = pending;
    if (rise_any)  pending_d = 1'b1;
    else if (clr)  pending_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= pending_d;
  end

  p_latch_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_any |=> pending);
  p_set_beats_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_any && clr) |=> pending);
endmodule

// File: rtl/whs_timer.sv
module whs_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = load_val;
    else if (dec && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  p_timer_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);
endmodule

// File: rtl/whs_heartbeat.sv
module whs_heartbeat #(
  parameter int PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_stb,
  output logic fault
);
  localparam int W = $clog2(PERIOD + 1);

  logic check;
  logic seen_q, seen_d;
  logic fault_d;

  whs_timer #(.W(W), .RST_VAL(PERIOD - 1)) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (check),
    .load_val (W'(PERIOD - 1)),
    .dec      (1'b1),
    .zero     (check)
  );

  always_comb begin
    seen_d  = seen_q | rx_stb;
    fault_d = fault;
    if (check) begin
      fault_d = ~(seen_q | rx_stb);
      seen_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      fault  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      fault  <= fault_d;
    end
  end

  p_fault_only_at_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(check));
  p_byte_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (check && rx_stb) |=> !fault);
endmodule

// File: rtl/wake_hold_seq.sv
module wake_hold_seq
  import whs_pkg::*;
#(
  parameter int NSRC       = 2,
  parameter int SETTLE_CYC = 1000,
  parameter int WAKE_CYC   = 8,
  parameter int HB_CYC     = 125_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_in,
  input  logic [NSRC-1:0] evt_en,
  input  logic            host_gpio,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  output logic            tx_valid,
  output logic [7:0]      tx_data,
  input  logic            tx_ready,
  output logic            wake_pulse,
  output logic            peer_fault
);
  localparam int TMAX = (SETTLE_CYC > WAKE_CYC) ? SETTLE_CYC : WAKE_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  whs_state_e  state_q, state_d;
  logic [7:0]  reply_q, reply_d;
  logic        gpio_q;
  logic        gpio_fall;
  logic        is_query, is_susp;
  logic        pending;
  logic        lat_clr;
  logic        tm_load;
  logic [TW-1:0] tm_val;
  logic        tm_zero;

  assign is_query  = rx_valid && (rx_data == MSG_QUERY);
  assign is_susp   = rx_valid && (rx_data == MSG_SUSPEND);
  assign gpio_fall = gpio_q && !host_gpio;
  assign lat_clr   = (state_q == ST_REPLY) && tx_ready && (reply_q == MSG_YES);

  whs_evt_latch #(.NSRC(NSRC)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_in  (evt_in),
    .evt_en  (evt_en),
    .clr     (lat_clr),
    .pending (pending)
  );

  whs_timer #(.W(TW), .RST_VAL(0)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tm_load),
    .load_val (tm_val),
    .dec      (1'b1),
    .zero     (tm_zero)
  );

  whs_heartbeat #(.PERIOD(HB_CYC)) u_hb (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_stb (rx_valid),
    .fault  (peer_fault)
  );

  always_comb begin
    state_d = state_q;
    reply_d = reply_q;
    tm_load = 1'b0;
    tm_val  = '0;
    case (state_q)
      ST_HOLD, ST_OFF: begin
        if (is_query) begin
          reply_d = pending ? MSG_YES : MSG_NO;
          state_d = ST_REPLY;
        end else if (is_susp) begin
          state_d = ST_SUSP;
        end else if (state_q == ST_OFF && pending) begin
          state_d = ST_WAKE;
          tm_load = 1'b1;
          tm_val  = TW'(WAKE_CYC - 1);
        end
      end
      ST_REPLY: begin
        if (tx_ready) state_d = ST_LIVE;
      end
      ST_LIVE: begin
        if (is_susp) begin
          state_d = ST_SUSP;
        end else if (is_query) begin
          reply_d = pending ? MSG_YES : MSG_NO;
          state_d = ST_REPLY;
        end else if (pending) begin
          reply_d = MSG_YES;
          state_d = ST_REPLY;
        end
      end
      ST_SUSP: begin
        if (gpio_fall) begin
          state_d = ST_SETTLE;
          tm_load = 1'b1;
          tm_val  = TW'(SETTLE_CYC - 1);
        end
      end
      ST_SETTLE: begin
        if (tm_zero) begin
          if (pending) begin
            state_d = ST_WAKE;
            tm_load = 1'b1;
            tm_val  = TW'(WAKE_CYC - 1);
          end else begin
            state_d = ST_OFF;
          end
        end
      end
      ST_WAKE: begin
        if (tm_zero) state_d = ST_HOLD;
      end
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      reply_q <= MSG_NO;
      gpio_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      reply_q <= reply_d;
      gpio_q  <= host_gpio;
    end
  end

  assign tx_valid   = (state_q == ST_REPLY);
  assign tx_data    = reply_q;
  assign wake_pulse = (state_q == ST_WAKE);

  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  p_reply_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_data == MSG_YES || tx_data == MSG_NO));
  p_wake_needs_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_pulse) |-> pending);
  p_silent_after_suspend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSP && is_query) |=> !tx_valid);
  p_no_wake_while_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !wake_pulse) |=> !wake_pulse);
endmodule

// File: tb/tb_wake_hold_seq.sv
module tb_wake_hold_seq;
  localparam int NSRC = 2;
  localparam int SET  = 20;
  localparam int WK   = 4;
  localparam int HB   = 300;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] evt_in;
  logic [NSRC-1:0] evt_en;
  logic            host_gpio;
  logic            rx_valid;
  logic [7:0]      rx_data;
  logic            tx_valid;
  logic [7:0]      tx_data;
  logic            tx_ready;
  logic            wake_pulse;
  logic            peer_fault;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  wake_hold_seq #(.NSRC(NSRC), .SETTLE_CYC(SET), .WAKE_CYC(WK), .HB_CYC(HB)) dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .evt_en(evt_en),
    .host_gpio(host_gpio), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .wake_pulse(wake_pulse), .peer_fault(peer_fault)
  );

  function automatic logic [7:0] exp_reply(input logic [NSRC-1:0] en, input int src);
    return en[src] ? 8'h01 : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_data  = b;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic pulse_evt(input int src);
    evt_in[src] = 1'b1;
    tick(); tick();
    evt_in[src] = 1'b0;
    tick();
  endtask

  task automatic expect_tx(input logic [7:0] exp, input string tag);
    int w = 0;
    while (!tx_valid && w < 10) begin tick(); w++; end
    chk(tx_valid && tx_data == exp, tag, {tx_valid, tx_data}, {1'b1, exp});
    tx_ready = 1'b1;
    tick();
    tx_ready = 1'b0;
  endtask

  task automatic expect_quiet(input int n, input string tag);
    bit bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (tx_valid || wake_pulse) bad = 1'b1;
      tick();
    end
    chk(!bad, tag, {tx_valid, wake_pulse}, 0);
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; evt_in = '0; evt_en = '1; host_gpio = 1'b0;
    rx_valid = 1'b0; rx_data = '0; tx_ready = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    host_gpio = 1'b1;
    tick();
    // R1 reset state
    chk(!wake_pulse && !tx_valid && !peer_fault, "R1 reset outputs",
        {wake_pulse, tx_valid, peer_fault}, 0);

    // R2 event before first query is held silently
    pulse_evt(0);
    expect_quiet(10, "R2 held before query");

    // R11 unknown byte ignored
    send_byte(8'h77);
    expect_quiet(5, "R11 unknown byte");

    // R3 query reports held event, then latch is clear
    send_byte(8'h51);
    expect_tx(8'h01, "R3 query yes");
    send_byte(8'h51);
    expect_tx(8'h00, "R3 query no after clear");

    // R2 masked source has no effect
    evt_en = 2'b10;
    pulse_evt(0);
    expect_quiet(10, "R2 masked source");
    evt_en = 2'b11;

    // R4 random live events and queries
    for (int it = 0; it < 24; it++) begin
      int src = $urandom % NSRC;
      evt_en = NSRC'($urandom);
      if ($urandom % 4 == 0) begin
        send_byte(8'h51);
        expect_tx(8'h00, "R3 random idle query");
      end
      pulse_evt(src);
      if (exp_reply(evt_en, src) == 8'h01) expect_tx(8'h01, "R4 live event sent");
      else expect_quiet(8, "R4 disabled live source");
    end
    evt_en = 2'b11;

    // R10 back-pressure keeps reply stable
    pulse_evt(1);
    begin
      bit bad = 1'b0;
      for (int i = 0; i < 5; i++) begin
        if (!(tx_valid && tx_data == 8'h01)) bad = 1'b1;
        tick();
      end
      chk(!bad, "R10 reply held", {tx_valid, tx_data}, 9'h101);
    end
    expect_tx(8'h01, "R10 reply after ready");

    // R5 suspend: events latched only, queries ignored
    send_byte(8'h53);
    pulse_evt(0);
    send_byte(8'h51);
    expect_quiet(10, "R5 silent after suspend");

    // R6 settle delay, R7 pulse width with pending event
    host_gpio = 1'b0;
    cnt = 0;
    while (!wake_pulse && cnt < 200) begin tick(); cnt++; end
    chk(cnt == SET + 1, "R6 settle delay", cnt, SET + 1);
    cnt = 0;
    while (wake_pulse && cnt < 50) begin tick(); cnt++; end
    chk(cnt == WK, "R7 wake width", cnt, WK);
    host_gpio = 1'b1;
    send_byte(8'h51);
    expect_tx(8'h01, "R7 held event reported after wake");

    // R8 nothing pending at end of settle, later event wakes
    send_byte(8'h53);
    host_gpio = 1'b0;
    expect_quiet(SET + 10, "R8 no wake without event");
    evt_in[1] = 1'b1;
    cnt = 0;
    while (!wake_pulse && cnt < 20) begin tick(); cnt++; end
    chk(cnt == 2, "R8 wake latency from off", cnt, 2);
    cnt = 0;
    while (wake_pulse && cnt < 50) begin tick(); cnt++; end
    chk(cnt == WK, "R8 wake width", cnt, WK);
    evt_in[1] = 1'b0;
    host_gpio = 1'b1;
    send_byte(8'h51);
    expect_tx(8'h01, "R8 event reported");

    // R9 heartbeat
    repeat (2 * HB + 10) tick();
    chk(peer_fault, "R9 fault on silence", peer_fault, 1);
    send_byte(8'h77);
    cnt = 0;
    while (peer_fault && cnt < HB + 5) begin tick(); cnt++; end
    chk(!peer_fault, "R9 fault cleared by byte", peer_fault, 0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule